// File: doc/BRIEF.md
# RTC Index/Data Port Controller

This block sits on the bus side of a legacy real-time-clock register file. It watches an 8-bit I/O bus that has an address, a write byte and separate read and write strobes. A window of four consecutive byte ports starts at a base address. Two of the ports are index ports and two are data ports. Each index port holds a 7-bit register number for one of two banks of clock registers: the standard bank and the extended bank. The data port paired with each index port then reads or writes the selected register.

A write to the standard index port also sets the NMI mask from bit 7 of the byte. It also keeps a full copy of the byte in a shadow output, because the index ports cannot be read back. Any write to either index port places the written byte on an address-latch output and raises a one-clock address-latch strobe toward the clock logic. In this project the clock register banks are a small test memory inside the block.

Top module: `rtc_port_ctrl`

## Requirements
- R1: While `rst` is high and after it falls, both indexes are 0, `nmi_masked` is 0, `shadow_idx` is 8'h00, `ale_pulse` is 0 and `bus_rdata` is 8'h00.
- R2: A write to offset 0 of the window (the standard index port) loads byte bits [6:0] into the standard index and bit 7 into `nmi_masked`, where 1 means NMI is masked and 0 means it is enabled. Both values are visible after the accepting clock edge.
- R3: A write to offset 0 or offset 2 raises `ale_pulse` for exactly the one clock cycle after the edge that accepts the write, and `ale_data` then shows the written byte.
- R4: A write to offset 1 stores the byte in the standard-bank register chosen by the standard index. A read at offset 1 returns that register on `bus_rdata` after the edge that samples the read.
- R5: Offsets 2 and 3 act on the extended bank through the extended index in the same way, including the highest index 7'h7F.
- R6: Bit 7 of a byte written to offset 2 is ignored: the writes 8'h85 and 8'h05 select the same extended register.
- R7: `shadow_idx` holds the full last byte written to offset 0, bit 7 included.
- R8: A read at offset 0 or offset 2 returns 8'hFF and leaves both indexes, `nmi_masked` and `shadow_idx` unchanged.
- R9: The two banks are separate storage, so the same index in each bank holds a different byte.
- R10: An access outside the four-port window changes no state, and a read there returns 8'hFF.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W | I/O byte address |
| bus_wdata | input | 8 | Write byte |
| bus_rd | input | 1 | Read strobe, one access per cycle high |
| bus_wr | input | 1 | Write strobe, one access per cycle high (takes precedence over read) |
| bus_rdata | output | 8 | Registered read result |
| nmi_masked | output | 1 | NMI mask state, 1 = masked |
| shadow_idx | output | 8 | Copy of last byte written to the standard index port |
| ale_pulse | output | 1 | One-cycle address-latch strobe toward the clock logic |
| ale_data | output | 8 | Byte that accompanies the address-latch strobe |

## Verification
The hardest case to reach from the ports is proving where a write landed, because both index registers are write-only. The bench never reads the index registers directly. It writes distinct bytes through the data ports under several index values, moves the index away, returns it, and reads back. This shows that a reserved bit, an index-port read or an out-of-window write did not move an index or cross into the other bank. The reset-index case is checked the same way: a data write made straight after reset must be found again at index 0.

// File: rtl/rtc_port_pkg.sv
package rtc_port_pkg;

    localparam int RTC_IDX_W = 7;
    localparam int BUS_DW    = 8;
    localparam int NUM_BANKS = 2;
    localparam int OFF_W     = 2;

    typedef enum logic [OFF_W-1:0] {
        PORT_STD_IDX = 2'd0,
        PORT_STD_DAT = 2'd1,
        PORT_EXT_IDX = 2'd2,
        PORT_EXT_DAT = 2'd3
    } port_off_e;

    typedef enum logic {
        BANK_STD = 1'b0,
        BANK_EXT = 1'b1
    } bank_e;

    typedef struct packed {
        logic              hit;
        logic              rd;
        logic              wr;
        port_off_e         off;
        logic [BUS_DW-1:0] wdata;
    } bus_req_t;

    typedef struct packed {
        logic                 we;
        bank_e                bank;
        logic [RTC_IDX_W-1:0] idx;
        logic [BUS_DW-1:0]    wdata;
    } mem_req_t;

    localparam logic [BUS_DW-1:0] IDLE_BYTE = 8'hFF;

    function automatic logic is_index_port(port_off_e off);
        return (off == PORT_STD_IDX) || (off == PORT_EXT_IDX);
    endfunction

    function automatic bank_e bank_of(port_off_e off);
        return (off == PORT_EXT_IDX || off == PORT_EXT_DAT) ? BANK_EXT : BANK_STD;
    endfunction

endpackage

// File: rtl/rtc_port_decode.sv
module rtc_port_decode
    import rtc_port_pkg::*;
#(
    parameter int              ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0070
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_DW-1:0] bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output bus_req_t          req
);
    logic in_window;

    // The window is aligned to four bytes; the low bits pick the port.
    assign in_window = (bus_addr[ADDR_W-1:OFF_W] == BASE_ADDR[ADDR_W-1:OFF_W]);

    always_comb begin
        req.hit   = in_window;
        req.wr    = bus_wr;
        req.rd    = bus_rd && !bus_wr;
        req.off   = port_off_e'(bus_addr[OFF_W-1:0]);
        req.wdata = bus_wdata;
    end
endmodule

// File: rtl/rtc_index_regs.sv
module rtc_index_regs
    import rtc_port_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  bus_req_t             req,
    output logic [RTC_IDX_W-1:0] idx_std,
    output logic [RTC_IDX_W-1:0] idx_ext,
    output logic                 nmi_masked,
    output logic [BUS_DW-1:0]    shadow_idx,
    output logic                 ale_pulse,
    output logic [BUS_DW-1:0]    ale_data
);
    logic idx_write;

    assign idx_write = req.hit && req.wr && is_index_port(req.off);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx_std    <= '0;
            idx_ext    <= '0;
            nmi_masked <= 1'b0;
            shadow_idx <= '0;
            ale_pulse  <= 1'b0;
            ale_data   <= '0;
        end else begin
            ale_pulse <= idx_write;
            if (idx_write) begin
                ale_data <= req.wdata;
                if (req.off == PORT_STD_IDX) begin
                    idx_std    <= req.wdata[RTC_IDX_W-1:0];
                    nmi_masked <= req.wdata[BUS_DW-1];
                    shadow_idx <= req.wdata;
                end else begin
                    // top bit of the extended index byte is reserved
                    idx_ext <= req.wdata[RTC_IDX_W-1:0];
                end
            end
        end
    end
endmodule

// File: rtl/rtc_test_mem.sv
module rtc_test_mem
    import rtc_port_pkg::*;
(
    input  logic              clk,
    input  mem_req_t          req,
    output logic [BUS_DW-1:0] rdata
);
    localparam int DEPTH = 1 << RTC_IDX_W;

    logic [BUS_DW-1:0] bank_rd [NUM_BANKS];

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic [BUS_DW-1:0] store [DEPTH];

        always_ff @(posedge clk) begin
            if (req.we && (int'(req.bank) == b))
                store[req.idx] <= req.wdata;
        end

        assign bank_rd[b] = store[req.idx];
    end

    assign rdata = bank_rd[int'(req.bank)];
endmodule

// File: rtl/rtc_port_ctrl.sv
module rtc_port_ctrl
    import rtc_port_pkg::*;
#(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0070
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_rd,
    input  logic              bus_wr,
    output logic [7:0]        bus_rdata,
    output logic              nmi_masked,
    output logic [7:0]        shadow_idx,
    output logic              ale_pulse,
    output logic [7:0]        ale_data
);
    bus_req_t             req;
    mem_req_t             mreq;
    logic [RTC_IDX_W-1:0] idx_std;
    logic [RTC_IDX_W-1:0] idx_ext;
    logic [BUS_DW-1:0]    mem_rdata;
    logic                 data_port;
    logic                 mem_we;

    rtc_port_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_dec (
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .req       (req)
    );

    rtc_index_regs u_idx (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .idx_std    (idx_std),
        .idx_ext    (idx_ext),
        .nmi_masked (nmi_masked),
        .shadow_idx (shadow_idx),
        .ale_pulse  (ale_pulse),
        .ale_data   (ale_data)
    );

    assign data_port = req.hit && !is_index_port(req.off);
    assign mem_we    = data_port && req.wr;

    always_comb begin
        mreq.we    = mem_we;
        mreq.bank  = bank_of(req.off);
        mreq.idx   = (bank_of(req.off) == BANK_EXT) ? idx_ext : idx_std;
        mreq.wdata = req.wdata;
    end

    rtc_test_mem u_mem (
        .clk   (clk),
        .req   (mreq),
        .rdata (mem_rdata)
    );

    // Registered read return: data ports give the indexed register,
    // every other read (index ports, outside the window) gives the idle byte.
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (req.rd) begin
            bus_rdata <= data_port ? mem_rdata : IDLE_BYTE;
        end
    end
endmodule

// File: rtl/rtc_port_ctrl_chk.sv
module rtc_port_ctrl_chk #(
    parameter int                ADDR_W    = 16,
    parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h0070
) (
    input logic              clk,
    input logic              rst,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [7:0]        bus_wdata,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [7:0]        bus_rdata,
    input logic              nmi_masked,
    input logic [7:0]        shadow_idx,
    input logic              ale_pulse,
    input logic [7:0]        ale_data
);
    localparam logic [ADDR_W-1:0] EXT_IDX_ADDR = ADDR_W'(BASE_ADDR + 2);

    logic wr_std_idx, wr_ext_idx, rd_idx_port;
    assign wr_std_idx  = bus_wr && (bus_addr == BASE_ADDR);
    assign wr_ext_idx  = bus_wr && (bus_addr == EXT_IDX_ADDR);
    assign rd_idx_port = bus_rd && !bus_wr &&
                         ((bus_addr == BASE_ADDR) || (bus_addr == EXT_IDX_ADDR));

    // R2
    nmi_follows_write_chk: assert property (@(posedge clk) disable iff (rst)
        wr_std_idx |=> nmi_masked == $past(bus_wdata[7]));

    // R3
    ale_on_index_write_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_std_idx || wr_ext_idx) |=> ale_pulse && ale_data == $past(bus_wdata));

    // R3
    ale_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(wr_std_idx || wr_ext_idx) |=> !ale_pulse);

    // R7
    shadow_copy_chk: assert property (@(posedge clk) disable iff (rst)
        wr_std_idx |=> shadow_idx == $past(bus_wdata));

    // R8
    shadow_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !wr_std_idx |=> $stable(shadow_idx) && $stable(nmi_masked));

    // R8
    index_read_idle_chk: assert property (@(posedge clk) disable iff (rst)
        rd_idx_port |=> bus_rdata == 8'hFF);
endmodule

bind rtc_port_ctrl rtc_port_ctrl_chk #(
    .ADDR_W    (ADDR_W),
    .BASE_ADDR (BASE_ADDR)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_rdata  (bus_rdata),
    .nmi_masked (nmi_masked),
    .shadow_idx (shadow_idx),
    .ale_pulse  (ale_pulse),
    .ale_data   (ale_data)
);

// File: tb/sim_rtc_port_ctrl.sv
module sim_rtc_port_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 16;
    localparam logic [15:0] B = 16'h0070;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_rdata;
    logic        nmi_masked;
    logic [7:0]  shadow_idx;
    logic        ale_pulse;
    logic [7:0]  ale_data;

    int tests = 0;
    int fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    rtc_port_ctrl #(.ADDR_W(ADDR_W), .BASE_ADDR(B)) u0 (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata(bus_rdata),
        .nmi_masked(nmi_masked), .shadow_idx(shadow_idx),
        .ale_pulse(ale_pulse), .ale_data(ale_data)
    );

    // rd=1: read at addr and expect data; rd=0: write data to addr
    typedef struct packed {
        logic        rd;
        logic [15:0] addr;
        logic [7:0]  data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 30;
    localparam vec_t VECS [NV] = '{
        '{1'b0, B+16'd0, 8'h05, 4'd4},  // R4 std index 5
        '{1'b0, B+16'd1, 8'hA1, 4'd4},
        '{1'b0, B+16'd0, 8'h06, 4'd4},
        '{1'b0, B+16'd1, 8'hB2, 4'd4},
        '{1'b0, B+16'd0, 8'h05, 4'd4},
        '{1'b1, B+16'd1, 8'hA1, 4'd4},  // R4 read back index 5
        '{1'b0, B+16'd0, 8'h06, 4'd4},
        '{1'b1, B+16'd1, 8'hB2, 4'd4},  // R4 read back index 6
        '{1'b0, B+16'd2, 8'h85, 4'd6},  // R6 reserved bit set
        '{1'b0, B+16'd3, 8'hC3, 4'd6},
        '{1'b0, B+16'd2, 8'h05, 4'd6},
        '{1'b1, B+16'd3, 8'hC3, 4'd6},  // R6 same register
        '{1'b0, B+16'd3, 8'hD4, 4'd9},  // R9 ext[5]
        '{1'b0, B+16'd0, 8'h05, 4'd9},
        '{1'b1, B+16'd1, 8'hA1, 4'd9},  // R9 std[5] intact
        '{1'b1, B+16'd3, 8'hD4, 4'd9},  // R9 ext[5]
        '{1'b1, B+16'd0, 8'hFF, 4'd8},  // R8 index read idle
        '{1'b1, B+16'd2, 8'hFF, 4'd8},  // R8
        '{1'b1, B+16'd1, 8'hA1, 4'd8},  // R8 std index unmoved
        '{1'b0, B+16'd4, 8'h06, 4'd10}, // R10 outside window
        '{1'b0, B-16'd3, 8'hEE, 4'd10},
        '{1'b1, B+16'd1, 8'hA1, 4'd10}, // R10 index and data intact
        '{1'b1, B+16'd4, 8'hFF, 4'd10}, // R10 idle read
        '{1'b0, B+16'd2, 8'h7F, 4'd5},  // R5 top index
        '{1'b0, B+16'd3, 8'h11, 4'd5},
        '{1'b0, B+16'd2, 8'h00, 4'd5},
        '{1'b0, B+16'd3, 8'h22, 4'd5},
        '{1'b0, B+16'd2, 8'h7F, 4'd5},
        '{1'b1, B+16'd3, 8'h11, 4'd5},  // R5
        '{1'b1, B+16'd1, 8'hA1, 4'd5}   // R5 std bank untouched
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic bus_write(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0] rv;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 nmi", {7'd0, nmi_masked}, 8'h00);
        check("R1 shadow", shadow_idx, 8'h00);
        check("R1 ale", {7'd0, ale_pulse}, 8'h00);
        check("R1 rdata", bus_rdata, 8'h00);
        rst = 1'b0;
        // R1 standard index starts at 0
        bus_write(B + 16'd1, 8'h5A);
        bus_write(B + 16'd0, 8'h01);
        bus_write(B + 16'd1, 8'h77);
        bus_write(B + 16'd0, 8'h00);
        bus_read(B + 16'd1, rv);
        check("R1 std index zero", rv, 8'h5A);
        // R1 extended index starts at 0
        bus_write(B + 16'd3, 8'h3C);
        bus_write(B + 16'd2, 8'h01);
        bus_write(B + 16'd3, 8'h44);
        bus_write(B + 16'd2, 8'h00);
        bus_read(B + 16'd3, rv);
        check("R1 ext index zero", rv, 8'h3C);

        // R2 R3 R7 standard index write with mask set
        bus_write(B, 8'h85);
        check("R2 nmi masked", {7'd0, nmi_masked}, 8'h01);
        check("R7 shadow", shadow_idx, 8'h85);
        check("R3 ale high", {7'd0, ale_pulse}, 8'h01);
        check("R3 ale data", ale_data, 8'h85);
        @(negedge clk);
        check("R3 ale one cycle", {7'd0, ale_pulse}, 8'h00);
        bus_write(B, 8'h03);
        check("R2 nmi enabled", {7'd0, nmi_masked}, 8'h00);
        check("R7 shadow", shadow_idx, 8'h03);
        // R3 extended index write
        bus_write(B + 16'd2, 8'hC7);
        check("R3 ale ext", {7'd0, ale_pulse}, 8'h01);
        check("R3 ale ext data", ale_data, 8'hC7);
        check("R7 shadow unchanged by ext", shadow_idx, 8'h03);
        // R3 no strobe on data write
        bus_write(B + 16'd1, 8'h99);
        check("R3 no ale on data", {7'd0, ale_pulse}, 8'h00);

        // R8 index port reads leave mask and shadow
        bus_write(B, 8'h83);
        bus_read(B, rv);
        check("R8 read std idx", rv, 8'hFF);
        check("R8 shadow kept", shadow_idx, 8'h83);
        check("R8 nmi kept", {7'd0, nmi_masked}, 8'h01);
        bus_read(B + 16'd2, rv);
        check("R8 read ext idx", rv, 8'hFF);

        // table walk
        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                bus_read(VECS[i].addr, rv);
                tests++;
                if (rv !== VECS[i].data) begin
                    fails++;
                    $display("FAIL vector %0d (R%0d): actual %02h expected %02h",
                             i, VECS[i].req, rv, VECS[i].data);
                end
            end else begin
                bus_write(VECS[i].addr, VECS[i].data);
            end
        end

        // R10 out-of-window write leaves mask and shadow
        bus_write(B + 16'd8, 8'h00);
        check("R10 shadow", shadow_idx, 8'h05);
        check("R10 nmi", {7'd0, nmi_masked}, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule